// File: doc/BRIEF.md
# I2C Pin Override for Bus Recovery

This block sits between an I2C protocol engine and the two open-drain pads of the bus (clock and data). In normal operation the engine's pull-down requests pass straight to the pads. When software sets the mode bit, both pads are taken from the engine and given to a small GPIO path. Through this path software can hold or release each line, for example to pulse the clock line until a stuck target frees the data line.

Each pad has its own direction bit and output latch. The latch can be loaded directly, or changed one bit at a time through a write-1-to-set register and a write-1-to-clear register. No read-modify-write is needed. The pad levels can be read back through a two-flop synchronizer. The pads are never driven high. A line is either pulled low or released to its external pull-up.

Pin index 0 is the clock line (SCL) and index 1 is the data line (SDA) in every per-pin field. Register offsets are fixed because software decodes them.

Top module: `i2c_pin_override`

## Requirements
- R1: After a synchronous reset, the mode bit, the direction bits and the output latch bits are all 0, so the pads follow the engine.
- R2: In engine mode (mode bit 0), each pad pull-low output equals the engine's pull request for that pad, whatever the direction and latch bits hold.
- R3: In GPIO mode (mode bit 1), a pad is pulled low exactly when its direction bit is 1 and its latch bit is 0. The engine requests have no effect in this mode.
- R4: A write to offset 0x58 sets each latch bit whose data bit is 1 (bit 0 SCL, bit 1 SDA) and leaves the bits written as 0 unchanged.
- R5: A write to offset 0x5C clears each latch bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R6: A write to offset 0x54 loads the latch directly from data bits 1:0. A read of 0x54 returns the latch in bits 1:0.
- R7: Offset 0x50 reads the pad levels (bit 0 SCL, bit 1 SDA) through a two-flop synchronizer. A pad change made between two clock edges is visible only after the second following rising edge.
- R8: Offset 0x48 holds the mode bit in bit 0 and offset 0x4C holds the direction bits (bit 0 SCL, bit 1 SDA, 1 = output). Both read back as written, with the upper bits reading 0.
- R9: The direction and latch bits keep their values across switches between engine mode and GPIO mode.
- R10: Writes to 0x50 or to unmapped offsets change no state. Reads of 0x58, 0x5C and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| eng_scl_pull | input | 1 | Engine requests SCL pulled low |
| eng_sda_pull | input | 1 | Engine requests SDA pulled low |
| scl_pad_in | input | 1 | Sensed SCL pad level (asynchronous) |
| sda_pad_in | input | 1 | Sensed SDA pad level (asynchronous) |
| scl_pull_low | output | 1 | Enables the SCL open-drain pull-down |
| sda_pull_low | output | 1 | Enables the SDA open-drain pull-down |

## Verification
The checker watches four things on every cycle:
- the set and clear writes change only the addressed latch bits;
- the latch stays stable across mode writes and across writes to ignored offsets;
- a GPIO-mode input pin never pulls its pad low, and a GPIO-mode output pin with latch 0 always does;
- the synchronized level equals the pad level from two edges earlier.

Several behaviours can only be shown by the bench's scenarios:
- engine passthrough while the GPIO bits are set;
- the exact readback encodings and zero upper bits;
- latch retention over a full round trip between modes;
- the first-edge and second-edge latency of a pad change;
- the return to engine control after a reset taken in GPIO mode.

// File: rtl/i2c_pinmux_pkg.sv
// Shared constants for the I2C pin override block.
// Offsets are byte addresses fixed by the software view.
package i2c_pinmux_pkg;

    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned PIN_SCL  = 0;
    localparam int unsigned PIN_SDA  = 1;

    localparam int unsigned OFS_MODE = 'h48;
    localparam int unsigned OFS_DIR  = 'h4C;
    localparam int unsigned OFS_LVL  = 'h50;
    localparam int unsigned OFS_OUT  = 'h54;
    localparam int unsigned OFS_SET  = 'h58;
    localparam int unsigned OFS_CLR  = 'h5C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIR,
        SEL_LVL,
        SEL_OUT,
        SEL_SET,
        SEL_CLR
    } reg_sel_e;

endpackage

// File: rtl/i2c_pinmux_sync.sv
// Two-flop synchronizer, one chain per pad.
// Assumes the pad inputs are asynchronous to clk.
// Resets to 1 because an idle I2C bus is released high.
module i2c_pinmux_sync #(
    parameter int unsigned NP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pad_async,
    output logic [NP-1:0] pad_sync
);

    for (genvar g = 0; g < NP; g++) begin : g_chain
        logic meta_q;
        logic stab_q;

        // Move one pad level through two flops into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= pad_async[g];
                stab_q <= meta_q;
            end
        end

        assign pad_sync[g] = stab_q;
    end

endmodule

// File: rtl/i2c_pinmux_regs.sv
// Register file for the override path: mode bit, direction bits,
// output latch with direct, set and clear access, and level readback.
// Assumes a single-cycle write strobe. Reads are combinational on addr.
module i2c_pinmux_regs
    import i2c_pinmux_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NP     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NP-1:0]     pin_lvl,
    output logic              gpio_mode,
    output logic [NP-1:0]     dir_q,
    output logic [NP-1:0]     latch_q,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e          sel;
    logic [NP-1:0]     wbits;
    logic              unused_hi;

    assign wbits     = wdata[NP-1:0];
    assign unused_hi = ^wdata[DATA_W-1:NP];

    // Decode the byte offset into a register select.
    always_comb begin
        if      (addr == ADDR_W'(OFS_MODE)) sel = SEL_MODE;
        else if (addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_LVL))  sel = SEL_LVL;
        else if (addr == ADDR_W'(OFS_OUT))  sel = SEL_OUT;
        else if (addr == ADDR_W'(OFS_SET))  sel = SEL_SET;
        else if (addr == ADDR_W'(OFS_CLR))  sel = SEL_CLR;
        else                                sel = SEL_NONE;
    end

    // Update mode, direction and latch on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_mode <= 1'b0;
            dir_q     <= '0;
            latch_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: gpio_mode <= wdata[0];
                SEL_DIR:  dir_q     <= wbits;
                SEL_OUT:  latch_q   <= wbits;
                SEL_SET:  latch_q   <= latch_q | wbits;
                SEL_CLR:  latch_q   <= latch_q & ~wbits;
                default:  ;
            endcase
        end
    end

    // Return the selected register, zero-extended.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_MODE: rdata[0]      = gpio_mode;
            SEL_DIR:  rdata[NP-1:0] = dir_q;
            SEL_LVL:  rdata[NP-1:0] = pin_lvl;
            SEL_OUT:  rdata[NP-1:0] = latch_q;
            default:  rdata         = '0;
        endcase
    end

endmodule

// File: rtl/i2c_pinmux_pad.sv
// Per-pad open-drain mux between engine requests and the GPIO path.
// The output enables a pull-down only. A pad is never driven high.
module i2c_pinmux_pad #(
    parameter int unsigned NP = 2
) (
    input  logic          gpio_mode,
    input  logic [NP-1:0] dir_q,
    input  logic [NP-1:0] latch_q,
    input  logic [NP-1:0] eng_pull,
    output logic [NP-1:0] pull_low
);

    for (genvar g = 0; g < NP; g++) begin : g_pad
        logic gpio_pull;

        // An output pin at level 0 pulls low. Level 1 or input releases.
        always_comb gpio_pull = dir_q[g] & ~latch_q[g];

        // Select the owner of the pad.
        always_comb pull_low[g] = gpio_mode ? gpio_pull : eng_pull[g];
    end

endmodule

// File: rtl/i2c_pin_override.sv
// Top of the I2C pin override block.
// Routes the engine's open-drain pull requests to the pads, or hands the
// pads to software-controlled GPIO latches when the mode bit is set.
// Assumes synchronous active-low reset and asynchronous pad inputs.
module i2c_pin_override
    import i2c_pinmux_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_scl_pull,
    input  logic              eng_sda_pull,
    input  logic              scl_pad_in,
    input  logic              sda_pad_in,
    output logic              scl_pull_low,
    output logic              sda_pull_low
);

    localparam int unsigned NP = NUM_PINS;

    logic [NP-1:0] pad_async;
    logic [NP-1:0] pad_sync;
    logic [NP-1:0] eng_pull;
    logic [NP-1:0] pull_low;
    logic          gpio_mode;
    logic [NP-1:0] dir_q;
    logic [NP-1:0] latch_q;

    // Gather per-pin inputs into index order (0 = SCL, 1 = SDA).
    always_comb begin
        pad_async[PIN_SCL] = scl_pad_in;
        pad_async[PIN_SDA] = sda_pad_in;
        eng_pull[PIN_SCL]  = eng_scl_pull;
        eng_pull[PIN_SDA]  = eng_sda_pull;
    end

    i2c_pinmux_sync #(.NP(NP)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_async (pad_async),
        .pad_sync  (pad_sync)
    );

    i2c_pinmux_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NP(NP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pin_lvl   (pad_sync),
        .gpio_mode (gpio_mode),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .rdata     (reg_rdata)
    );

    i2c_pinmux_pad #(.NP(NP)) u_pad (
        .gpio_mode (gpio_mode),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .eng_pull  (eng_pull),
        .pull_low  (pull_low)
    );

    // Split the pad enables back into named outputs.
    always_comb begin
        scl_pull_low = pull_low[PIN_SCL];
        sda_pull_low = pull_low[PIN_SDA];
    end

endmodule

// File: rtl/i2c_pin_override_chk.sv
// Checker for i2c_pin_override, attached with bind.
// Watches latch updates, mode isolation, open-drain output and
// synchronizer latency.
module i2c_pin_override_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        gpio_mode,
    input logic [1:0]  dir_q,
    input logic [1:0]  latch_q,
    input logic [1:0]  pad_sync,
    input logic        scl_pad_in,
    input logic        sda_pad_in,
    input logic        scl_pull_low,
    input logic        sda_pull_low
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating, to gate the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h58) |=> latch_q == ($past(latch_q) | $past(reg_wdata[1:0])));

    assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h5C) |=> latch_q == ($past(latch_q) & ~$past(reg_wdata[1:0])));

    assert_mode_keeps_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h48) |=> ($stable(latch_q) && $stable(dir_q)));

    assert_ignored_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != 8'h54 && reg_addr != 8'h58 && reg_addr != 8'h5C)
        |=> $stable(latch_q));

    assert_input_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_mode && !dir_q[0]) |-> !scl_pull_low);

    assert_output_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_mode && dir_q[1] && !latch_q[1]) |-> sda_pull_low);

    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> pad_sync == $past({sda_pad_in, scl_pad_in}, 2));

endmodule

bind i2c_pin_override i2c_pin_override_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .gpio_mode    (gpio_mode),
    .dir_q        (dir_q),
    .latch_q      (latch_q),
    .pad_sync     (pad_sync),
    .scl_pad_in   (scl_pad_in),
    .sda_pad_in   (sda_pad_in),
    .scl_pull_low (scl_pull_low),
    .sda_pull_low (sda_pull_low)
);

// File: tb/i2c_pin_override_tb.sv
// Bench for i2c_pin_override. Pads are modelled as open-drain wires with
// pull-ups. Vector fields, from the top bit down:
// wr | addr | wdata | eng{sda,scl} | exp_pull{sda,scl} | rd_addr | exp_rdata
module i2c_pin_override_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic [1:0]  eng = 2'b00;
    logic [1:0]  ext_low = 2'b00;
    logic        scl_pull_low;
    logic        sda_pull_low;
    logic        scl_pad;
    logic        sda_pad;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign scl_pad = ~(scl_pull_low | ext_low[0]);
    assign sda_pad = ~(sda_pull_low | ext_low[1]);

    i2c_pin_override u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .eng_scl_pull (eng[0]),
        .eng_sda_pull (eng[1]),
        .scl_pad_in   (scl_pad),
        .sda_pad_in   (sda_pad),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low)
    );

    localparam int NV = 19;
    localparam logic [52:0] VEC [NV] = '{
        {1'b0, 8'h00, 16'h0000, 2'b01, 2'b01, 8'h48, 16'h0000}, // R2 engine scl
        {1'b0, 8'h00, 16'h0000, 2'b10, 2'b10, 8'h48, 16'h0000}, // R2 engine sda
        {1'b1, 8'h4C, 16'h0003, 2'b00, 2'b00, 8'h4C, 16'h0003}, // R2 dir ignored, R8
        {1'b1, 8'h48, 16'h0001, 2'b11, 2'b11, 8'h48, 16'h0001}, // R3 gpio, latch 0
        {1'b1, 8'h58, 16'h0001, 2'b00, 2'b10, 8'h54, 16'h0001}, // R4 set scl
        {1'b1, 8'h58, 16'h0002, 2'b00, 2'b00, 8'h54, 16'h0003}, // R4 set sda
        {1'b1, 8'h5C, 16'h0001, 2'b00, 2'b01, 8'h54, 16'h0002}, // R5 clr scl
        {1'b1, 8'h58, 16'h0000, 2'b00, 2'b01, 8'h54, 16'h0002}, // R4 zero bits
        {1'b1, 8'h5C, 16'h0000, 2'b00, 2'b01, 8'h54, 16'h0002}, // R5 zero bits
        {1'b1, 8'h4C, 16'h0001, 2'b00, 2'b01, 8'h4C, 16'h0001}, // R3 sda input
        {1'b1, 8'h54, 16'h0001, 2'b00, 2'b00, 8'h54, 16'h0001}, // R6 direct load
        {1'b1, 8'h4C, 16'h0003, 2'b00, 2'b10, 8'h4C, 16'h0003}, // R3 sda out 0
        {1'b1, 8'h48, 16'h0000, 2'b01, 2'b01, 8'h54, 16'h0001}, // R9 back to engine
        {1'b1, 8'h50, 16'h0003, 2'b00, 2'b00, 8'h54, 16'h0001}, // R10 write lvl
        {1'b1, 8'h60, 16'hFFFF, 2'b00, 2'b00, 8'h60, 16'h0000}, // R10 unmapped
        {1'b0, 8'h00, 16'h0000, 2'b00, 2'b00, 8'h58, 16'h0000}, // R10 read set
        {1'b0, 8'h00, 16'h0000, 2'b00, 2'b00, 8'h5C, 16'h0000}, // R10 read clr
        {1'b1, 8'h48, 16'h0001, 2'b00, 2'b10, 8'h50, 16'h0001}, // R9 R7 gpio again
        {1'b1, 8'h48, 16'hFFFE, 2'b00, 2'b00, 8'h48, 16'h0000}  // R8 upper bits
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, pads follow the engine.
        rd_chk("R1 mode", 8'h48, 16'h0000);
        rd_chk("R1 dir", 8'h4C, 16'h0000);
        rd_chk("R1 latch", 8'h54, 16'h0000);
        rd_chk("R7 idle level", 8'h50, 16'h0003);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr = VEC[i][52]; reg_addr = VEC[i][51:44];
            reg_wdata = VEC[i][43:28]; eng = VEC[i][27:26];
            @(negedge clk);
            reg_wr = 1'b0;
            repeat (2) @(negedge clk);
            #1;
            check($sformatf("vec %0d pull", i), {14'd0, sda_pull_low, scl_pull_low},
                  {14'd0, VEC[i][25:24]});
            rd_chk($sformatf("vec %0d read", i), VEC[i][23:16], VEC[i][15:0]);
        end

        // R7: latency of a pad change is two edges.
        @(negedge clk);
        eng = 2'b00;
        ext_low = 2'b10;
        rd_chk("R7 before edge", 8'h50, 16'h0003);
        @(negedge clk);
        rd_chk("R7 after one edge", 8'h50, 16'h0003);
        @(negedge clk);
        rd_chk("R7 after two edges", 8'h50, 16'h0001);
        ext_low = 2'b00;
        repeat (2) @(negedge clk);

        // R1: reset taken in GPIO mode returns the pads to the engine.
        wr_reg(8'h4C, 16'h0003);
        wr_reg(8'h54, 16'h0000);
        wr_reg(8'h48, 16'h0001);
        eng = 2'b00;
        #1;
        check("R3 both pulled", {14'd0, sda_pull_low, scl_pull_low}, 16'h0003);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        eng = 2'b10;
        #1;
        check("R1 engine after reset", {14'd0, sda_pull_low, scl_pull_low}, 16'h0002);
        rd_chk("R1 mode after reset", 8'h48, 16'h0000);
        rd_chk("R1 dir after reset", 8'h4C, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule